// File: doc/BRIEF.md
# Dual-Polynomial CRC Engine

This block is a register-mapped checksum unit. Software uses it so the processor does not have to compute CRCs itself. A configuration register chooses, at run time, between the 16-bit CCITT polynomial (0x1021) and the 32-bit Ethernet polynomial (0x04C11DB7). The same configuration register also chooses the input chunk size, byte-wise bit reflection and output inversion. Each write to the data register folds one chunk, up to a whole 32-bit word, into the running CRC during the clock edge that accepts the write. Every access completes with no wait states.

The running state is held in a value register. Software writes that register to load a seed and reads it to collect the result. A read is a combinational mux of the register contents, so a read in the cycle after a write already shows the updated CRC.

The register map uses a 2-bit word address: 0 is the configuration register, 1 is the data register, 2 is the value register and 3 is unmapped. The configuration bits are:

- bit 0 selects narrow mode (1 = 16-bit CCITT, 0 = 32-bit Ethernet).
- bit 1 selects reflection.
- bit 2 selects output inversion.
- bits 4:3 select the chunk size: 00 = 32 bits, 01 = 16 bits, 10 or 11 = 8 bits.

Top module: `crc_engine_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the configuration register reads 0 and the value register reads 0xFFFFFFFF.
- R2: With bit 0 of the configuration register clear, each data write folds its chunk into the state using the polynomial 0x04C11DB7, most significant data bit first, with no reflection. With seed 0xFFFFFFFF and no inversion, the nine bytes of ASCII "123456789" give 0x0376E6E7.
- R3: With bit 0 set, the fold uses the polynomial 0x1021 on a 16-bit state, and reads of the value register have bits 31:16 at zero. With seed 0xFFFF, "123456789" gives 0x29B1.
- R4: Bit 1 reverses the bit order inside each data byte before the fold and reverses the whole state (16 or 32 bits) on read. Bit 2 inverts the read value over the active width. With both bits set and seed 0xFFFFFFFF, "123456789" reads 0xCBF43926.
- R5: Bits 4:3 set the chunk size: 00 folds all 32 bits of write data, 01 folds bits 15:0, and 10 or 11 folds bits 7:0. Data bits above the chunk are ignored. In every case the higher byte is folded first.
- R6: A write to the value register loads the raw state (before reflection or inversion). A read of the value register in the next cycle shows that state passed through the R4 view.
- R7: Each data write takes effect at the edge that accepts it. Back-to-back writes in consecutive cycles are each folded in. When no write is presented, the state holds.
- R8: Address 3 reads 0, and a write to it changes neither the configuration nor the state.
- R9: In narrow mode, a seed write keeps only bits 15:0. A configuration write that sets bit 0 clears state bits 31:16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, accepted at the rising edge |
| bus_addr | input | 2 | Word address: 0 configuration, 1 data, 2 value, 3 unmapped |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
The bench builds the engine with its default parameters: a 32-bit bus word, the 0x04C11DB7 wide polynomial and the 0x1021 narrow polynomial. These defaults put the published check values for "123456789" within reach in the plain, reflected-and-inverted and CCITT forms. The same message is delivered as bytes, as halfwords with junk in the upper bits, and as words followed by a byte, so every chunk setting must reach the same result. Streams of random back-to-back words are then compared against a bit-serial model kept in the bench. Narrow-mode seed truncation and the unmapped address are checked at the read port.

// File: rtl/crc_eng_pkg.sv
// Package: shared configuration layout and register addresses for the CRC engine.
// Assumes a 2-bit word address and a 5-bit configuration field.
package crc_eng_pkg;

    // Configuration register fields, most significant first (bits 4:0)
    typedef struct packed {
        logic [1:0] chunk;    // 00 = 32 bits, 01 = 16 bits, else 8 bits
        logic       invert;   // invert read value over active width
        logic       reflect;  // byte-wise input reflection and result reflection
        logic       narrow;   // 1 = 16-bit CCITT, 0 = 32-bit Ethernet
    } crc_cfg_t;

    localparam int CFG_W = $bits(crc_cfg_t);

    localparam logic [1:0] ADDR_CFG  = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_VAL  = 2'd2;

endpackage

// File: rtl/crc_input_prep.sv
// crc_input_prep: turns a bus write word into the bits to fold and their count.
// Assumes the bus width is a whole number of bytes. Reflection reverses the
// bits inside each byte and keeps the byte order.
module crc_input_prep #(
    parameter int DATA_W = 32,
    localparam int BYTES  = DATA_W / 8,
    localparam int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [1:0]        chunk_i,
    input  logic              reflect_i,
    output logic [DATA_W-1:0] data_o,
    output logic [CNT_W-1:0]  nbits_o
);

    logic [DATA_W-1:0] swapped;

    // Bit reversal inside every byte lane
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        for (genvar k = 0; k < 8; k++) begin : g_bit
            assign swapped[b*8 + k] = wdata_i[b*8 + 7 - k];
        end
    end

    // Pick the reflected or the plain word
    always_comb data_o = reflect_i ? swapped : wdata_i;

    // Number of low-order bits taken from the word
    always_comb begin
        case (chunk_i)
            2'b00:   nbits_o = CNT_W'(DATA_W);
            2'b01:   nbits_o = CNT_W'(16);
            default: nbits_o = CNT_W'(8);
        endcase
    end

endmodule

// File: rtl/crc_fold_core.sv
// crc_fold_core: folds up to DATA_W bits into the CRC state in one cycle,
// most significant bit first. It is purely combinational. Assumes the state
// bits above NARROW_W are already zero in narrow mode.
module crc_fold_core #(
    parameter int             DATA_W    = 32,
    parameter int             STATE_W   = 32,
    parameter int             NARROW_W  = 16,
    parameter logic [STATE_W-1:0]  POLY_WIDE   = 32'h04C1_1DB7,
    parameter logic [NARROW_W-1:0] POLY_NARROW = 16'h1021,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic [STATE_W-1:0] state_i,
    input  logic [DATA_W-1:0]  data_i,
    input  logic [CNT_W-1:0]   nbits_i,
    input  logic               narrow_i,
    output logic [STATE_W-1:0] next_o
);

    localparam logic [STATE_W-1:0] NARROW_MASK = STATE_W'({NARROW_W{1'b1}});
    localparam logic [STATE_W-1:0] POLY_N_EXT  = STATE_W'(POLY_NARROW);

    // Unrolled shift-register division over the active data bits
    always_comb begin
        logic [STATE_W-1:0] acc;
        logic               fb;
        acc = state_i;
        fb  = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (i < int'(nbits_i)) begin
                fb  = (narrow_i ? acc[NARROW_W-1] : acc[STATE_W-1]) ^ data_i[i];
                acc = {acc[STATE_W-2:0], 1'b0};
                if (fb) begin
                    acc = acc ^ (narrow_i ? POLY_N_EXT : POLY_WIDE);
                end
                if (narrow_i) begin
                    acc = acc & NARROW_MASK;
                end
            end
        end
        next_o = acc;
    end

endmodule

// File: rtl/crc_result_fmt.sv
// crc_result_fmt: presents the raw state as the software-visible result, with
// optional reflection and inversion over the active width. Bits above the
// narrow width are forced to zero in narrow mode.
module crc_result_fmt #(
    parameter int STATE_W  = 32,
    parameter int NARROW_W = 16
) (
    input  logic [STATE_W-1:0] state_i,
    input  logic               narrow_i,
    input  logic               reflect_i,
    input  logic               invert_i,
    output logic [STATE_W-1:0] view_o
);

    localparam logic [STATE_W-1:0] NARROW_MASK = STATE_W'({NARROW_W{1'b1}});

    logic [STATE_W-1:0]  rev_wide;
    logic [NARROW_W-1:0] rev_narrow;

    // Full-width bit reversal
    for (genvar k = 0; k < STATE_W; k++) begin : g_rw
        assign rev_wide[k] = state_i[STATE_W-1-k];
    end

    // Narrow-width bit reversal
    for (genvar k = 0; k < NARROW_W; k++) begin : g_rn
        assign rev_narrow[k] = state_i[NARROW_W-1-k];
    end

    // Select the reflected or plain view, then apply inversion and masking
    always_comb begin
        logic [STATE_W-1:0] mask;
        mask   = narrow_i ? NARROW_MASK : '1;
        if (reflect_i) begin
            view_o = narrow_i ? STATE_W'(rev_narrow) : rev_wide;
        end else begin
            view_o = state_i;
        end
        if (invert_i) begin
            view_o = view_o ^ mask;
        end
        view_o = view_o & mask;
    end

endmodule

// File: rtl/crc_engine_top.sv
// crc_engine_top: register wrapper around the one-cycle CRC fold. It holds the
// configuration and the running state, takes writes at the clock edge and
// returns read data combinationally, so no access waits. Reset is synchronous
// and active low.
module crc_engine_top #(
    parameter int                 DATA_W      = 32,
    parameter int                 NARROW_W    = 16,
    parameter logic [DATA_W-1:0]  POLY_WIDE   = 32'h04C1_1DB7,
    parameter logic [NARROW_W-1:0] POLY_NARROW = 16'h1021,
    parameter logic [DATA_W-1:0]  RESET_SEED  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    import crc_eng_pkg::*;

    localparam int STATE_W = DATA_W;
    localparam int CNT_W   = $clog2(DATA_W + 1);
    localparam logic [STATE_W-1:0] NARROW_MASK = STATE_W'({NARROW_W{1'b1}});

    crc_cfg_t           cfg_q;
    logic [STATE_W-1:0] state_q;
    logic [DATA_W-1:0]  fold_data;
    logic [CNT_W-1:0]   fold_nbits;
    logic [STATE_W-1:0] fold_next;
    logic [STATE_W-1:0] view;
    crc_cfg_t           cfg_new;

    crc_input_prep #(.DATA_W(DATA_W)) u_prep (
        .wdata_i   (bus_wdata),
        .chunk_i   (cfg_q.chunk),
        .reflect_i (cfg_q.reflect),
        .data_o    (fold_data),
        .nbits_o   (fold_nbits)
    );

    crc_fold_core #(
        .DATA_W      (DATA_W),
        .STATE_W     (STATE_W),
        .NARROW_W    (NARROW_W),
        .POLY_WIDE   (POLY_WIDE),
        .POLY_NARROW (POLY_NARROW)
    ) u_fold (
        .state_i  (state_q),
        .data_i   (fold_data),
        .nbits_i  (fold_nbits),
        .narrow_i (cfg_q.narrow),
        .next_o   (fold_next)
    );

    crc_result_fmt #(.STATE_W(STATE_W), .NARROW_W(NARROW_W)) u_fmt (
        .state_i   (state_q),
        .narrow_i  (cfg_q.narrow),
        .reflect_i (cfg_q.reflect),
        .invert_i  (cfg_q.invert),
        .view_o    (view)
    );

    // Configuration value carried by a configuration write
    always_comb cfg_new = crc_cfg_t'(bus_wdata[CFG_W-1:0]);

    // Configuration register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (bus_wr && bus_addr == ADDR_CFG) begin
            cfg_q <= cfg_new;
        end
    end

    // State register: reset seed, fold on data write, load on seed write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RESET_SEED;
        end else if (bus_wr) begin
            case (bus_addr)
                ADDR_DATA: state_q <= fold_next;
                ADDR_VAL:  state_q <= cfg_q.narrow ? (bus_wdata & NARROW_MASK) : bus_wdata;
                ADDR_CFG:  if (cfg_new.narrow) state_q <= state_q & NARROW_MASK;
                default:   state_q <= state_q;
            endcase
        end
    end

    // Zero-wait read mux
    always_comb begin
        case (bus_addr)
            ADDR_CFG: bus_rdata = DATA_W'(cfg_q);
            ADDR_VAL: bus_rdata = view;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/crc_engine_chk.sv
// crc_engine_chk: temporal checks on crc_engine_top, attached by bind.
module crc_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [31:0] state_q,
    input logic [4:0]  cfg_bits
);

    assert_cfg_only_by_cfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != 2'd0) |=> $stable(cfg_bits));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(state_q));

    assert_seed_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && !cfg_bits[0]) |=> state_q == $past(bus_wdata));

    assert_narrow_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bits[0] |-> state_q[31:16] == 16'h0);

    assert_hole_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == 2'd3 |-> bus_rdata == 32'h0);

    assert_narrow_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bits[0] && bus_addr == 2'd2) |-> bus_rdata[31:16] == 16'h0);

endmodule

bind crc_engine_top crc_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .state_q   (state_q),
    .cfg_bits  (cfg_q)
);

// File: tb/tb_crc_engine_top.sv
// Scoreboard bench: driver tasks queue expected read values, a monitor pops and compares.
module tb_crc_engine_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;

    crc_engine_top dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct { logic [31:0] exp; string tag; } item_t;
    item_t exp_q[$];
    logic  probe = 1'b0;
    int    n_checks = 0;
    int    n_fail = 0;

    // Bench model state
    logic [4:0]  m_cfg = 5'h0;
    logic [31:0] m_state = 32'hFFFF_FFFF;

    function automatic logic [31:0] ref_fold(logic [31:0] s, logic [31:0] d, logic [4:0] c);
        int n;
        logic nar, refl, bitv, top;
        nar  = c[0];
        refl = c[1];
        n = (c[4:3] == 2'b00) ? 32 : (c[4:3] == 2'b01) ? 16 : 8;
        for (int k = n - 1; k >= 0; k--) begin
            bitv = refl ? d[(k / 8) * 8 + (7 - (k % 8))] : d[k];
            top  = nar ? s[15] : s[31];
            s = s << 1;
            if (top ^ bitv) s = s ^ (nar ? 32'h0000_1021 : 32'h04C1_1DB7);
            if (nar) s = s & 32'h0000_FFFF;
        end
        return s;
    endfunction

    function automatic logic [31:0] ref_view(logic [31:0] s, logic [4:0] c);
        int w;
        logic [31:0] r;
        w = c[0] ? 16 : 32;
        r = 32'h0;
        for (int k = 0; k < w; k++) r[k] = c[1] ? s[w - 1 - k] : s[k];
        if (c[2]) for (int k = 0; k < w; k++) r[k] = ~r[k];
        return r;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        probe = 1'b0;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        case (a)
            2'd0: begin m_cfg = d[4:0]; if (d[0]) m_state = m_state & 32'hFFFF; end
            2'd1: m_state = ref_fold(m_state, d, m_cfg);
            2'd2: m_state = m_cfg[0] ? (d & 32'hFFFF) : d;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_addr = a; bus_wdata = 32'h0;
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        probe = 1'b1;
    endtask

    task automatic idle();
        @(posedge clk); #1;
        bus_wr = 1'b0; probe = 1'b0;
    endtask

    // Monitor: compare read data away from the active edge
    always @(negedge clk) begin
        if (probe && exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            n_checks++;
            if (bus_rdata !== it.exp) begin
                n_fail++;
                $display("FAIL %s actual=%08h expected=%08h", it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic feed_bytes(input string s);
        for (int i = 0; i < s.len(); i++) wr(2'd1, {24'hA5A5A5, s[i]});
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R7 actual=hung expected=complete");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd(2'd0, 32'h0, "R1 cfg after reset");
        rd(2'd2, 32'hFFFF_FFFF, "R1 value after reset");

        // R2: plain CRC-32, bytes
        wr(2'd0, 32'h10);
        wr(2'd2, 32'hFFFF_FFFF);
        feed_bytes("123456789");
        rd(2'd2, 32'h0376_E6E7, "R2 plain crc32 check");
        rd(2'd2, ref_view(m_state, m_cfg), "R2 model");

        // R4: reflected and inverted, bytes
        wr(2'd0, 32'h16);
        wr(2'd2, 32'hFFFF_FFFF);
        feed_bytes("123456789");
        rd(2'd2, 32'hCBF4_3926, "R4 reflected crc32 bytes");
        rd(2'd0, 32'h16, "R4 cfg readback");

        // R5: words then a byte
        wr(2'd0, 32'h06);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd1, 32'h3132_3334);
        wr(2'd1, 32'h3536_3738);
        wr(2'd0, 32'h16);
        wr(2'd1, 32'hFFFF_FF39);
        rd(2'd2, 32'hCBF4_3926, "R5 words plus byte");

        // R5: halfwords with junk above
        wr(2'd0, 32'h0E);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd1, 32'hDEAD_3132);
        wr(2'd1, 32'hBEEF_3334);
        wr(2'd1, 32'h1234_3536);
        wr(2'd1, 32'h0000_3738);
        wr(2'd0, 32'h16);
        wr(2'd1, 32'h0000_0039);
        rd(2'd2, 32'hCBF4_3926, "R5 halfwords plus byte");

        // R3: CCITT narrow
        wr(2'd0, 32'h11);
        wr(2'd2, 32'h0000_FFFF);
        feed_bytes("123456789");
        rd(2'd2, 32'h0000_29B1, "R3 ccitt check");

        // R9: narrow seed truncation and narrowing an existing state
        wr(2'd2, 32'hABCD_1234);
        rd(2'd2, 32'h0000_1234, "R9 narrow seed");
        wr(2'd0, 32'h10);
        wr(2'd2, 32'h89AB_CDEF);
        wr(2'd0, 32'h11);
        rd(2'd2, 32'h0000_CDEF, "R9 narrowing clears top");

        // R6: raw seed load, read through reflect/invert view
        wr(2'd0, 32'h06);
        wr(2'd2, 32'h0000_0001);
        rd(2'd2, 32'h7FFF_FFFF, "R6 seed view");
        wr(2'd0, 32'h00);
        rd(2'd2, 32'h0000_0001, "R6 raw seed");

        // R8: unmapped address
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, 32'h0, "R8 hole reads zero");
        rd(2'd2, 32'h0000_0001, "R8 state untouched");
        rd(2'd0, 32'h0, "R8 cfg untouched");

        // R7: back-to-back random words in several modes, then idle hold
        for (int mode = 0; mode < 4; mode++) begin
            logic [4:0] cv;
            cv = (mode == 0) ? 5'h00 : (mode == 1) ? 5'h06 : (mode == 2) ? 5'h01 : 5'h0B;
            wr(2'd0, {27'h0, cv});
            wr(2'd2, $urandom());
            for (int j = 0; j < 12; j++) wr(2'd1, $urandom());
            rd(2'd2, ref_view(m_state, m_cfg), "R7 burst vs model");
            idle(); idle();
            rd(2'd2, ref_view(m_state, m_cfg), "R7 hold when idle");
        end

        idle(); idle();
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R7 actual=%0d expected=0 pending reads", exp_q.size());
        end
        finish_run();
    end

endmodule